// File: doc/BRIEF.md
# Flash Block Write-Protect Unit

This block sits in front of a flash controller and filters every program or erase request against a software-set protection boundary. It holds an 8-bit protect register, written and read over a simple single-cycle CPU register port. From that value it forms a 16-bit protection start address on a 512-byte page boundary. Any request at or above that start address, up to the top of the address space, is refused. A small group of special register codes selects either whole-array protection or protection of nothing but the top region.

The top 49 bytes of the map hold a mask-option byte and the user vector table. This region is refused whatever the register holds. Requests that are allowed pass through unchanged on a valid/ready handshake toward the flash controller. A refused request is taken in one cycle, is never forwarded, and sets a sticky violation flag that software clears with a strobe. The flash array occupies 0x0800 to 0xFFFF. A request below that window is taken and dropped, and the block raises a separate out-of-range indication for it.

Top module: `flash_wprot`

## Requirements
- R1: After reset the protect register reads 0x00 and the violation flag is 0.
- R2: A write (reg_we high for one cycle) loads reg_wdata into the register, reg_rdata shows the new value from the next cycle on, and a request presented in the same cycle as the write is still judged with the old value.
- R3: For register values 0x0A to 0xFB the start address is {reg[7:1], 9'b0}; a request at or above it is refused, and a request below it (and at or above 0x0800) is forwarded.
- R4: Register bit 0 does not move the start address: 0x0A and 0x0B give the same decisions.
- R5: Register values 0x00 to 0x09 refuse every request in 0x0800 to 0xFFFF.
- R6: Register values 0xFC, 0xFD, 0xFE and 0xFF refuse only 0xFFCF to 0xFFFF and forward every other request in the array.
- R7: Requests to 0xFFCF to 0xFFFF are refused for every register value.
- R8: An allowed request drives fwd_valid high with fwd_addr and fwd_erase equal to the request, and req_ready follows fwd_ready.
- R9: A refused request sees req_ready high in the same cycle, never raises fwd_valid, and sets viol_flag at the accepting clock edge.
- R10: viol_flag stays set until a cycle with viol_clr high clears it; when a refused request and viol_clr occur in the same cycle, the flag stays set.
- R11: A request below 0x0800 sees req_ready high, raises req_oor in that cycle, is not forwarded, and leaves viol_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Protect register write strobe |
| reg_wdata | input | 8 | Protect register write data |
| reg_rdata | output | 8 | Current protect register value |
| req_valid | input | 1 | Program/erase request valid |
| req_ready | output | 1 | Request taken this cycle |
| req_addr | input | 16 | Request address |
| req_erase | input | 1 | Request type: 1 erase, 0 program |
| fwd_valid | output | 1 | Allowed request toward flash controller |
| fwd_ready | input | 1 | Flash controller can take the request |
| fwd_addr | output | 16 | Forwarded address |
| fwd_erase | output | 1 | Forwarded request type |
| req_oor | output | 1 | Current request lies below the flash window |
| viol_flag | output | 1 | Sticky refused-request flag |
| viol_clr | input | 1 | Clears viol_flag |

## Verification
The decision logic is exercised with addresses on both sides of each boundary. These are one below and exactly at the page start, at 0xFFCE and 0xFFCF next to the vector region, and at the bottom and just below the flash window. Each is tried under a register value of each class: whole-array codes, ordinary page codes with bit 0 clear and set, the three top codes, and the open code. The pairs around a boundary expose an off-by-one compare or a wrong shift. Comparing 0x0A with 0x0B, and 0xFC to 0xFE with 0xFF, shows whether bit 0 or the special codes leak into the start address. Separate scenarios cover the write-then-request timing, the flag set/clear collision and back-pressure from downstream.

// File: rtl/fwp_pkg.sv
// Package: shared types for the flash write-protect unit.
// Assumes: nothing beyond the 1800-2017 language.
package fwp_pkg;
    // Protection class selected by the protect register value.
    typedef enum logic [1:0] {
        PROT_ALL        = 2'd0,  // whole array refused
        PROT_FROM_START = 2'd1,  // refuse from page start upwards
        PROT_VEC_ONLY   = 2'd2   // only the fixed top region refused
    } prot_mode_e;
endpackage

// File: rtl/fwp_prot_reg.sv
// Module: fwp_prot_reg
// Holds the block-protect value written over the register port.
// Assumes: single-cycle write strobe, synchronous active-low reset to 0.
module fwp_prot_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Register update: reset clears, write strobe loads.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    // R1: reset brings the register to zero
    assert_reg_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R2: written data is visible on the following cycle
    assert_reg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(wdata)));

    // R2: without a write the value holds
    assert_reg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/fwp_range_decode.sv
// Module: fwp_range_decode
// Turns the protect value into a start address and classifies one address.
// Assumes: ADDR_W == (DATA_W-1) + PAGE_SHIFT, purely combinational.
module fwp_range_decode
    import fwp_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter int              DATA_W     = 8,
    parameter int              PAGE_SHIFT = 9,
    parameter logic [15:0]     MAP_LO     = 16'h0800,
    parameter logic [15:0]     VEC_LO     = 16'hFFCF,
    parameter logic [7:0]      ALL_MAX    = 8'h09,
    parameter logic [7:0]      TOP_MIN    = 8'hFC
) (
    input  logic [DATA_W-1:0] cfg,
    input  logic [ADDR_W-1:0] addr,
    output prot_mode_e        mode,
    output logic [ADDR_W-1:0] start_addr,
    output logic              in_map,
    output logic              prot
);
    localparam int FIELD_W = DATA_W - 1;
    localparam logic [ADDR_W-1:0] MAP_LO_A = ADDR_W'(MAP_LO);
    localparam logic [ADDR_W-1:0] VEC_LO_A = ADDR_W'(VEC_LO);

    logic vec_hit;

    // Classify the register value into one of three protection classes.
    always_comb begin
        if (cfg <= DATA_W'(ALL_MAX))      mode = PROT_ALL;
        else if (cfg >= DATA_W'(TOP_MIN)) mode = PROT_VEC_ONLY;
        else                              mode = PROT_FROM_START;
    end

    // Page-aligned start address from the upper register bits.
    always_comb begin
        start_addr = ADDR_W'(cfg[DATA_W-1 -: FIELD_W]) << PAGE_SHIFT;
    end

    // Address classification against window, vector region and start.
    always_comb begin
        in_map  = (addr >= MAP_LO_A);
        vec_hit = (addr >= VEC_LO_A);
        prot    = vec_hit
                | (mode == PROT_ALL)
                | ((mode == PROT_FROM_START) && (addr >= start_addr));
    end
endmodule

// File: rtl/fwp_req_gate.sv
// Module: fwp_req_gate
// Passes allowed requests downstream, drops refused and unmapped ones,
// and keeps the sticky violation flag.
// Assumes: prot/in_map are valid whenever req_valid is high.
module fwp_req_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic in_map,
    input  logic prot,
    input  logic fwd_ready,
    input  logic viol_clr,
    output logic req_ready,
    output logic fwd_valid,
    output logic req_oor,
    output logic viol_flag
);
    logic blocked;
    logic allowed;

    // Handshake steering: allowed requests wait on downstream, others are taken now.
    always_comb begin
        allowed   = in_map && !prot;
        blocked   = req_valid && in_map && prot;
        req_oor   = req_valid && !in_map;
        fwd_valid = req_valid && allowed;
        req_ready = allowed ? fwd_ready : 1'b1;
    end

    // Sticky violation flag: a refused request wins over the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        viol_flag <= 1'b0;
        else if (blocked)  viol_flag <= 1'b1;
        else if (viol_clr) viol_flag <= 1'b0;
    end

    // R9: a refused request is taken and not forwarded
    assert_block_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_map && prot) |-> (req_ready && !fwd_valid));

    // R9: a refused request leaves the flag set
    assert_block_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_map && prot) |=> viol_flag);

    // R10: flag holds without a clear
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !viol_clr) |=> viol_flag);

    // R10: clear without a new refusal empties the flag
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_clr && !(req_valid && in_map && prot)) |=> !viol_flag);

    // R11: unmapped requests are taken, not forwarded, and leave the flag alone
    assert_oor_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_oor |-> (req_ready && !fwd_valid));
    assert_oor_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_oor && !viol_clr) |=> (viol_flag == $past(viol_flag)));
endmodule

// File: rtl/flash_wprot.sv
// Module: flash_wprot (top)
// Flash block write-protect unit: protect register, range decode and
// request gate. Forwards allowed program/erase requests unchanged.
// Assumes: synchronous active-low reset; downstream obeys valid/ready.
module flash_wprot
    import fwp_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter int          PAGE_SHIFT = 9,
    parameter logic [15:0] MAP_LO     = 16'h0800,
    parameter logic [15:0] VEC_LO     = 16'hFFCF,
    parameter logic [7:0]  ALL_MAX    = 8'h09,
    parameter logic [7:0]  TOP_MIN    = 8'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_erase,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              fwd_erase,
    output logic              req_oor,
    output logic              viol_flag,
    input  logic              viol_clr
);
    localparam logic [ADDR_W-1:0] MAP_LO_A = ADDR_W'(MAP_LO);
    localparam logic [ADDR_W-1:0] VEC_LO_A = ADDR_W'(VEC_LO);
    localparam logic [DATA_W-1:0] OPEN_CODE = '1;

    logic [DATA_W-1:0] cfg_q;
    prot_mode_e        mode;
    logic [ADDR_W-1:0] start_addr;
    logic              in_map;
    logic              prot;

    fwp_prot_reg #(.DATA_W(DATA_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .q     (cfg_q)
    );

    fwp_range_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT),
        .MAP_LO(MAP_LO), .VEC_LO(VEC_LO), .ALL_MAX(ALL_MAX), .TOP_MIN(TOP_MIN)
    ) u_dec (
        .cfg        (cfg_q),
        .addr       (req_addr),
        .mode       (mode),
        .start_addr (start_addr),
        .in_map     (in_map),
        .prot       (prot)
    );

    fwp_req_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .in_map    (in_map),
        .prot      (prot),
        .fwd_ready (fwd_ready),
        .viol_clr  (viol_clr),
        .req_ready (req_ready),
        .fwd_valid (fwd_valid),
        .req_oor   (req_oor),
        .viol_flag (viol_flag)
    );

    // Register readback and pass-through payload.
    always_comb begin
        reg_rdata = cfg_q;
        fwd_addr  = req_addr;
        fwd_erase = req_erase;
    end

    // R7: the vector region is never forwarded
    assert_vec_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= VEC_LO_A) |-> !fwd_valid);

    // R6: open code forwards everything in the window below the vector region
    assert_open_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && reg_rdata == OPEN_CODE && req_addr >= MAP_LO_A
         && req_addr < VEC_LO_A) |-> (fwd_valid && req_ready == fwd_ready));

    // R3: start address always lies on a page boundary
    assert_page_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_addr[PAGE_SHIFT-1:0] == '0));

    // R5: whole-array class forwards nothing
    assert_whole_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PROT_ALL) |-> !fwd_valid);
endmodule

// File: tb/tb_flash_wprot.sv
// Directed bench for flash_wprot: one task per scenario.
module tb_flash_wprot;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = 16'h0000;
    logic        req_erase = 1'b0;
    logic        fwd_valid;
    logic        fwd_ready = 1'b1;
    logic [15:0] fwd_addr;
    logic        fwd_erase;
    logic        req_oor;
    logic        viol_flag;
    logic        viol_clr = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        s_fwd, s_rdy, s_oor, s_ferase;
    logic [15:0] s_faddr;

    always #2.5 clk = ~clk;

    flash_wprot dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_erase(req_erase),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
        .fwd_addr(fwd_addr), .fwd_erase(fwd_erase),
        .req_oor(req_oor), .viol_flag(viol_flag), .viol_clr(viol_clr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Register write: strobe for one cycle.
    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // One-cycle clear strobe.
    task automatic clr_flag();
        @(negedge clk);
        viol_clr = 1'b1;
        @(negedge clk);
        viol_clr = 1'b0;
    endtask

    // Present one request for one cycle, sample before the accepting edge.
    task automatic probe(input logic [15:0] a, input logic er);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_erase = er;
        #1;
        s_fwd = fwd_valid; s_rdy = req_ready; s_oor = req_oor;
        s_faddr = fwd_addr; s_ferase = fwd_erase;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Expect forward (1) or refusal (0) of an address.
    task automatic expect_fwd(input logic [15:0] a, input bit exp, input string tag);
        probe(a, 1'b0);
        check(s_fwd == exp, tag, s_fwd, exp);
    endtask

    task automatic t_reset();
        check(reg_rdata == 8'h00, "R1 reset register", reg_rdata, 8'h00);
        check(viol_flag == 1'b0, "R1 reset flag", viol_flag, 0);
    endtask

    task automatic t_write_timing();
        wr_reg(8'hFF);
        check(reg_rdata == 8'hFF, "R2 readback", reg_rdata, 8'hFF);
        // write 0x00 and request in the same cycle: old value (open) applies
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = 8'h00;
        req_valid = 1'b1; req_addr = 16'h1000;
        #1;
        check(fwd_valid == 1'b1, "R2 same-cycle old value", fwd_valid, 1);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        check(fwd_valid == 1'b0, "R2 next-cycle new value", fwd_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
        clr_flag();
    endtask

    task automatic t_page_start();
        wr_reg(8'h0A);
        expect_fwd(16'h09FF, 1'b1, "R3 below start 0A");
        expect_fwd(16'h0A00, 1'b0, "R3 at start 0A");
        expect_fwd(16'hF000, 1'b0, "R3 above start 0A");
        wr_reg(8'hF4);
        expect_fwd(16'hF3FF, 1'b1, "R3 below start F4");
        expect_fwd(16'hF400, 1'b0, "R3 at start F4");
        clr_flag();
    endtask

    task automatic t_bit0();
        wr_reg(8'h0B);
        expect_fwd(16'h09FF, 1'b1, "R4 0B below start");
        expect_fwd(16'h0A00, 1'b0, "R4 0B at start");
        wr_reg(8'h81);
        expect_fwd(16'h7FFF, 1'b1, "R4 81 below start");
        expect_fwd(16'h8000, 1'b0, "R4 81 at start");
        clr_flag();
    endtask

    task automatic t_whole();
        wr_reg(8'h09);
        expect_fwd(16'h0800, 1'b0, "R5 09 bottom");
        expect_fwd(16'hFFCE, 1'b0, "R5 09 top");
        wr_reg(8'h00);
        expect_fwd(16'h4000, 1'b0, "R5 00 middle");
        clr_flag();
    endtask

    task automatic t_top_codes();
        for (int i = 0; i < 4; i++) begin
            wr_reg(8'hFC + 8'(i));
            expect_fwd(16'h0800, 1'b1, "R6 top code bottom");
            expect_fwd(16'hFFCE, 1'b1, "R6 top code below vectors");
            expect_fwd(16'hFFCF, 1'b0, "R7 vector low");
            expect_fwd(16'hFFFF, 1'b0, "R7 vector high");
        end
        clr_flag();
    endtask

    task automatic t_forward();
        wr_reg(8'hFF);
        probe(16'h2345, 1'b1);
        check(s_fwd && s_rdy, "R8 forward valid/ready", {s_fwd, s_rdy}, 3);
        check(s_faddr == 16'h2345, "R8 forward addr", s_faddr, 16'h2345);
        check(s_ferase == 1'b1, "R8 forward type", s_ferase, 1);
        fwd_ready = 1'b0;
        probe(16'h2346, 1'b0);
        check(s_fwd && !s_rdy, "R8 back-pressure", {s_fwd, s_rdy}, 2);
        fwd_ready = 1'b1;
    endtask

    task automatic t_flag();
        wr_reg(8'h40);
        clr_flag();
        fwd_ready = 1'b0;
        probe(16'h9000, 1'b0);
        fwd_ready = 1'b1;
        check(s_rdy && !s_fwd, "R9 refused taken, not forwarded", {s_fwd, s_rdy}, 1);
        check(viol_flag == 1'b1, "R9 flag set", viol_flag, 1);
        expect_fwd(16'h1000, 1'b1, "R10 allowed request");
        check(viol_flag == 1'b1, "R10 flag sticky", viol_flag, 1);
        clr_flag();
        check(viol_flag == 1'b0, "R10 flag cleared", viol_flag, 0);
        @(negedge clk);
        viol_clr = 1'b1; req_valid = 1'b1; req_addr = 16'hA000;
        @(negedge clk);
        viol_clr = 1'b0; req_valid = 1'b0;
        check(viol_flag == 1'b1, "R10 set wins over clear", viol_flag, 1);
        clr_flag();
    endtask

    task automatic t_oor();
        wr_reg(8'hFF);
        clr_flag();
        probe(16'h07FF, 1'b0);
        check(s_oor && s_rdy && !s_fwd, "R11 below window", {s_oor, s_rdy, s_fwd}, 6);
        check(viol_flag == 1'b0, "R11 flag untouched", viol_flag, 0);
        probe(16'h0800, 1'b0);
        check(!s_oor && s_fwd, "R11 window bottom", {s_oor, s_fwd}, 1);
        wr_reg(8'h00);
        probe(16'h0100, 1'b0);
        check(s_oor && !s_fwd, "R11 below window locked", {s_oor, s_fwd}, 2);
        check(viol_flag == 1'b0, "R11 no flag when locked", viol_flag, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_write_timing();
        t_page_start();
        t_bit0();
        t_whole();
        t_top_codes();
        t_forward();
        t_flag();
        t_oor();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule